// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit processor's 16-bit address bus and a large external program ROM with an optional battery-style RAM. A write that lands in the ROM address space never stores data. It loads one of four control fields instead: a RAM gate, a 5-bit lower bank number, a 2-bit upper bank number and a banking-mode flag. Reads, and RAM writes while the gate is open, are translated into physical ROM or RAM addresses. A response code says which memory answers, or that none does.

A cart-type strap selects the mapping. Type 0 is a plain pass-through with no banking. Types 1, 2 and 3 use the banked mapping. Every other type is reported as unsupported and gets no response. The banking mode is a two-state machine. `MODE_SIMPLE` is entered at reset. In it, the fixed lower ROM window and the RAM always use bank 0. `MODE_ADVANCED` lets the 2-bit upper field also select the lower ROM window's bank and the RAM bank. A control write to 0x6000–0x7FFF moves the machine: `MODE_SIMPLE` goes to `MODE_ADVANCED` when data bit 0 is 1, `MODE_ADVANCED` returns to `MODE_SIMPLE` when it is 0, and any other write leaves the state alone. Returned read data comes from the responding memory, or is 0xFF when nothing responds. Physical addresses are cut to the fitted ROM and RAM widths, so out-of-range banks wrap.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with cart type 1–3 to 0x0000–0x1FFF opens the RAM gate when data[3:0] equals 0xA and closes it for any other value; the new state is seen from the next clock.
- R2: A write with cart type 1–3 to 0x2000–0x3FFF loads the lower bank field with data[4:0], storing 1 when those bits are 0.
- R3: A write with cart type 1–3 to 0x4000–0x5FFF loads the upper bank field with data[1:0].
- R4: A write with cart type 1–3 to 0x6000–0x7FFF drives the mode machine to MODE_ADVANCED when data[0] is 1 and to MODE_SIMPLE when it is 0.
- R5: After reset the lower field is 1, the upper field is 0, the gate is closed and the mode is MODE_SIMPLE.
- R6: With the banked mapping, a read of 0x0000–0x3FFF gives rom_addr = bank*0x4000 + addr[13:0], where bank is upper<<5 in MODE_ADVANCED and 0 in MODE_SIMPLE.
- R7: With the banked mapping, a read of 0x4000–0x7FFF gives rom_addr = (upper<<5 | lower)*0x4000 + addr[13:0].
- R8: With the banked mapping, an access to 0xA000–0xBFFF gives ram_addr = bank*0x2000 + addr[12:0], where bank is upper in MODE_ADVANCED and 0 in MODE_SIMPLE. It responds, and a write asserts ram_we, only while the gate is open.
- R9: Cart type 0 maps 0x0000–0x7FFF straight to rom_addr = addr, and maps 0xA000–0xBFFF to ram_addr = addr − 0xA000 for reads and writes whatever the gate state. Writes to the ROM space change no control field.
- R10: Cart types 1, 2 and 3 select the banked mapping with unsupported = 0. Any other type drives unsupported = 1, response none and ram_we = 0.
- R11: rom_addr and ram_addr are the translated addresses reduced modulo 2^ROM_AW and 2^RAM_AW.
- R12: The resp encoding is 2'b00 none, 2'b01 ROM and 2'b10 RAM. An idle bus, an address outside the mapped ranges, or a RAM access with the gate closed gives none, and then cpu_rdata is 0xFF.
- R13: cpu_rdata returns rom_rdata on a ROM response and ram_rdata on a RAM response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cart_type | input | 8 | Cart-type strap selecting the mapping |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe; a control write takes effect at the clock edge |
| rom_rdata | input | 8 | Data from the external ROM |
| ram_rdata | input | 8 | Data from the external RAM |
| cpu_rdata | output | 8 | Read data returned to the processor |
| resp | output | 2 | Responder: 00 none, 01 ROM, 10 RAM |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_we | output | 1 | RAM write enable |
| unsupported | output | 1 | Cart type has no mapping |

## Verification
The bench writes a zero lower bank through a data byte whose upper bits are set. A design that stored the raw value would map bank 0 into the upper window instead of bank 1. It reads the lower window and the RAM in both modes, and runs write–read pairs in the gate region with nibbles near 0xA. A design that tested the whole byte, or ignored the mode, would give the wrong address or open the gate wrongly. It drives control writes under the pass-through type, then switches to a banked type to show that the fields kept their old values. A second, narrower instance shows that wrapping drops the high bank bits instead of saturating them.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int BANK_LO_W = 5;
    localparam int BANK_HI_W = 2;
    localparam int ROM_OFF_W = 14;
    localparam int RAM_OFF_W = 13;
    localparam int ROM_FULL_W = BANK_HI_W + BANK_LO_W + ROM_OFF_W;
    localparam int RAM_FULL_W = BANK_HI_W + RAM_OFF_W;

    typedef enum logic [1:0] {
        RESP_NONE = 2'b00,
        RESP_ROM  = 2'b01,
        RESP_RAM  = 2'b10
    } resp_e;

    typedef enum logic {
        MODE_SIMPLE   = 1'b0,
        MODE_ADVANCED = 1'b1
    } bmode_e;

    typedef enum logic [1:0] {
        MAP_PASS   = 2'd0,
        MAP_BANKED = 2'd1,
        MAP_UNSUP  = 2'd2
    } mapper_e;

    typedef enum logic [1:0] {
        SEL_GATE  = 2'd0,
        SEL_LOW   = 2'd1,
        SEL_HIGH  = 2'd2,
        SEL_MODE  = 2'd3
    } ctl_sel_e;

endpackage

// File: rtl/cbc_type_dec.sv
module cbc_type_dec
    import cbc_pkg::*;
(
    input  logic [7:0] cart_type_i,
    output mapper_e    kind_o
);

    always_comb begin
        unique case (cart_type_i)
            8'h00:               kind_o = MAP_PASS;
            8'h01, 8'h02, 8'h03: kind_o = MAP_BANKED;
            default:             kind_o = MAP_UNSUP;
        endcase
    end

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [1:0]           ctl_sel,
    input  logic [BANK_LO_W-1:0] ctl_data,
    output logic                 ram_en_o,
    output logic [BANK_LO_W-1:0] low_o,
    output logic [BANK_HI_W-1:0] high_o,
    output bmode_e               mode_o
);

    bmode_e               mode_q, mode_d;
    logic                 gate_q;
    logic [BANK_LO_W-1:0] low_q;
    logic [BANK_HI_W-1:0] high_q;
    logic                 hit_gate, hit_low, hit_high, hit_mode;

    assign hit_gate = ctl_we && (ctl_sel == SEL_GATE);
    assign hit_low  = ctl_we && (ctl_sel == SEL_LOW);
    assign hit_high = ctl_we && (ctl_sel == SEL_HIGH);
    assign hit_mode = ctl_we && (ctl_sel == SEL_MODE);

    // Mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_SIMPLE;
        else        mode_q <= mode_d;
    end

    // Mode next-state logic
    always_comb begin
        mode_d = mode_q;
        if (hit_mode) begin
            unique case (mode_q)
                MODE_SIMPLE:   if (ctl_data[0])  mode_d = MODE_ADVANCED;
                MODE_ADVANCED: if (!ctl_data[0]) mode_d = MODE_SIMPLE;
                default:       mode_d = MODE_SIMPLE;
            endcase
        end
    end

    // Control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            low_q  <= BANK_LO_W'(1);
            high_q <= '0;
        end else begin
            if (hit_gate) gate_q <= (ctl_data[3:0] == 4'hA);
            if (hit_low)  low_q  <= (ctl_data == '0) ? BANK_LO_W'(1) : ctl_data;
            if (hit_high) high_q <= ctl_data[BANK_HI_W-1:0];
        end
    end

    assign ram_en_o = gate_q;
    assign low_o    = low_q;
    assign high_o   = high_q;
    assign mode_o   = mode_q;

    a_r1_gate_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        hit_gate |=> (gate_q == ($past(ctl_data[3:0]) == 4'hA)));

    a_r2_low_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_low && ctl_data == '0) |=> (low_q == BANK_LO_W'(1)));

    a_r3_high_load: assert property (@(posedge clk) disable iff (!rst_n)
        hit_high |=> (high_q == $past(ctl_data[BANK_HI_W-1:0])));

    a_r4_mode_follow: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mode |=> (mode_q == ($past(ctl_data[0]) ? MODE_ADVANCED : MODE_SIMPLE)));

    a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> ($stable(low_q) && $stable(high_q) && $stable(gate_q) && $stable(mode_q)));

endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate
    import cbc_pkg::*;
#(
    parameter int ROM_AW = 21,
    parameter int RAM_AW = 15
) (
    input  mapper_e              kind_i,
    input  logic [15:0]          addr_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    input  logic                 ram_en_i,
    input  logic [BANK_LO_W-1:0] low_i,
    input  logic [BANK_HI_W-1:0] high_i,
    input  bmode_e               mode_i,
    output resp_e                resp_o,
    output logic [ROM_AW-1:0]    rom_addr_o,
    output logic [RAM_AW-1:0]    ram_addr_o,
    output logic                 ram_we_o
);

    localparam int LOWIN_W = BANK_HI_W + BANK_LO_W;

    logic [ROM_FULL_W-1:0] rom_full;
    logic [RAM_FULL_W-1:0] ram_full;
    logic [LOWIN_W-1:0]    lowin_bank;
    logic [BANK_HI_W-1:0]  ram_bank;
    logic                  in_lo, in_hi, in_ram, ram_ok, live;

    assign in_lo  = (addr_i[15:14] == 2'b00);
    assign in_hi  = (addr_i[15:14] == 2'b01);
    assign in_ram = (addr_i[15:13] == 3'b101);

    always_comb begin
        lowin_bank = (mode_i == MODE_ADVANCED) ? {high_i, {BANK_LO_W{1'b0}}} : '0;
        ram_bank   = (mode_i == MODE_ADVANCED) ? high_i : '0;
        rom_full   = '0;
        ram_full   = '0;
        ram_ok     = 1'b0;
        live       = 1'b0;
        unique case (kind_i)
            MAP_PASS: begin
                rom_full = {{(ROM_FULL_W-15){1'b0}}, addr_i[14:0]};
                ram_full = {{BANK_HI_W{1'b0}}, addr_i[RAM_OFF_W-1:0]};
                ram_ok   = 1'b1;
                live     = 1'b1;
            end
            MAP_BANKED: begin
                rom_full = in_lo ? {lowin_bank, addr_i[ROM_OFF_W-1:0]}
                                 : {high_i, low_i, addr_i[ROM_OFF_W-1:0]};
                ram_full = {ram_bank, addr_i[RAM_OFF_W-1:0]};
                ram_ok   = ram_en_i;
                live     = 1'b1;
            end
            default: begin
                live = 1'b0;
            end
        endcase
    end

    always_comb begin
        resp_o   = RESP_NONE;
        ram_we_o = 1'b0;
        if (live && wr_i) begin
            if (in_ram && ram_ok) begin
                resp_o   = RESP_RAM;
                ram_we_o = 1'b1;
            end
        end else if (live && rd_i) begin
            if (in_lo || in_hi)       resp_o = RESP_ROM;
            else if (in_ram && ram_ok) resp_o = RESP_RAM;
        end
    end

    assign rom_addr_o = ROM_AW'(rom_full);
    assign ram_addr_o = RAM_AW'(ram_full);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_AW = 21,
    parameter int RAM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cart_type,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [7:0]        rom_rdata,
    input  logic [7:0]        ram_rdata,
    output logic [7:0]        cpu_rdata,
    output logic [1:0]        resp,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic              unsupported
);

    mapper_e              kind;
    bmode_e               mode;
    resp_e                resp_s;
    logic                 ram_en;
    logic [BANK_LO_W-1:0] low;
    logic [BANK_HI_W-1:0] high;
    logic                 ctl_we;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^cpu_wdata[7:BANK_LO_W];

    cbc_type_dec u_type (
        .cart_type_i (cart_type),
        .kind_o      (kind)
    );

    assign ctl_we = cpu_wr && (kind == MAP_BANKED) && !cpu_addr[15];

    cbc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we   (ctl_we),
        .ctl_sel  (cpu_addr[14:13]),
        .ctl_data (cpu_wdata[BANK_LO_W-1:0]),
        .ram_en_o (ram_en),
        .low_o    (low),
        .high_o   (high),
        .mode_o   (mode)
    );

    cbc_xlate #(
        .ROM_AW (ROM_AW),
        .RAM_AW (RAM_AW)
    ) u_xlate (
        .kind_i     (kind),
        .addr_i     (cpu_addr),
        .rd_i       (cpu_rd),
        .wr_i       (cpu_wr),
        .ram_en_i   (ram_en),
        .low_i      (low),
        .high_i     (high),
        .mode_i     (mode),
        .resp_o     (resp_s),
        .rom_addr_o (rom_addr),
        .ram_addr_o (ram_addr),
        .ram_we_o   (ram_we)
    );

    always_comb begin
        unique case (resp_s)
            RESP_ROM: cpu_rdata = rom_rdata;
            RESP_RAM: cpu_rdata = ram_rdata;
            default:  cpu_rdata = 8'hFF;
        endcase
    end

    assign resp        = resp_s;
    assign unsupported = (kind == MAP_UNSUP);

    a_r8_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b101 && (kind == MAP_PASS || ram_en)));

    a_r10_unsup_silent: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (resp_s == RESP_NONE && !ram_we));

    a_r12_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (resp_s == RESP_NONE && cpu_rdata == 8'hFF));

endmodule

// File: tb/tb_cart_bank_ctrl.sv
module tb_cart_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cart_type = 8'h01;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  rom_rdata = 8'h5A;
    logic [7:0]  ram_rdata = 8'hC3;

    logic [7:0]  cpu_rdata, s_rdata;
    logic [1:0]  resp, s_resp;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic [15:0] s_rom_addr;
    logic [13:0] s_ram_addr;
    logic        ram_we, unsupported, s_we, s_unsup;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cart_bank_ctrl #(.ROM_AW(21), .RAM_AW(15)) dut (
        .clk(clk), .rst_n(rst_n), .cart_type(cart_type), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata),
        .resp(resp), .rom_addr(rom_addr), .ram_addr(ram_addr),
        .ram_we(ram_we), .unsupported(unsupported)
    );

    cart_bank_ctrl #(.ROM_AW(16), .RAM_AW(14)) dut_small (
        .clk(clk), .rst_n(rst_n), .cart_type(cart_type), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .cpu_rdata(s_rdata),
        .resp(s_resp), .rom_addr(s_rom_addr), .ram_addr(s_ram_addr),
        .ram_we(s_we), .unsupported(s_unsup)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic ctl_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(posedge clk);
        #1 cpu_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
    endtask

    task automatic probe_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        #1;
    endtask

    task automatic end_write();
        @(posedge clk);
        #1 cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        #1;
        check("R12 idle resp", resp, 2'b00);
        check("R12 idle rdata", cpu_rdata, 8'hFF);
        do_read(16'h4123);
        check("R5 low=1 resp", resp, 2'b01);
        check("R5 low=1 addr", rom_addr, 32'h4123);
        do_read(16'h0123);
        check("R5 simple lower", rom_addr, 32'h0123);
        do_read(16'hA000);
        check("R5 gate closed resp", resp, 2'b00);
        check("R12 gate closed rdata", cpu_rdata, 8'hFF);
    endtask

    task automatic t_gate();
        ctl_write(16'h0000, 8'h3A);
        do_read(16'hA010);
        check("R1 open resp", resp, 2'b10);
        check("R13 ram data", cpu_rdata, 8'hC3);
        ctl_write(16'h1FFF, 8'h0B);
        do_read(16'hA010);
        check("R1 closed by 0x0B", resp, 2'b00);
        ctl_write(16'h1000, 8'hFA);
        do_read(16'hA010);
        check("R1 open by 0xFA", resp, 2'b10);
        ctl_write(16'h0800, 8'hAB);
        do_read(16'hA010);
        check("R1 closed by 0xAB", resp, 2'b00);
    endtask

    task automatic t_low_bank();
        ctl_write(16'h2000, 8'h00);
        do_read(16'h4000);
        check("R2 zero stored as 1", rom_addr, 32'h4000);
        ctl_write(16'h3FFF, 8'hE5);
        do_read(16'h5001);
        check("R2 low=5", rom_addr, 32'h15001);
        ctl_write(16'h2100, 8'h20);
        do_read(16'h4000);
        check("R2 masked zero -> 1", rom_addr, 32'h4000);
    endtask

    task automatic t_upper();
        ctl_write(16'h2000, 8'h03);
        ctl_write(16'h4000, 8'hFE);
        do_read(16'h7FFF);
        check("R3 R7 bank 67", rom_addr, 32'h10FFFF);
        check("R13 rom data", cpu_rdata, 8'h5A);
        check("R11 rom wrap", s_rom_addr, 32'hFFFF);
        ctl_write(16'h5FFF, 8'h01);
        do_read(16'h4000);
        check("R3 R7 bank 35", rom_addr, 32'h8C000);
    endtask

    task automatic t_lower_mode();
        ctl_write(16'h4000, 8'h02);
        ctl_write(16'h6000, 8'h00);
        do_read(16'h0100);
        check("R6 simple lower", rom_addr, 32'h0100);
        ctl_write(16'h7FFF, 8'h01);
        do_read(16'h0100);
        check("R4 R6 advanced lower", rom_addr, 32'h100100);
        do_read(16'h3FFF);
        check("R6 advanced lower top", rom_addr, 32'h103FFF);
        ctl_write(16'h6000, 8'hFE);
        do_read(16'h0100);
        check("R4 back to simple", rom_addr, 32'h0100);
    endtask

    task automatic t_ram_bank();
        ctl_write(16'h0000, 8'h0A);
        ctl_write(16'h6000, 8'h01);
        do_read(16'hB234);
        check("R8 advanced ram addr", ram_addr, 32'h5234);
        check("R8 ram resp", resp, 2'b10);
        check("R11 ram wrap", s_ram_addr, 32'h1234);
        probe_write(16'hA005, 8'h77);
        check("R8 write we", ram_we, 1'b1);
        check("R8 write resp", resp, 2'b10);
        check("R8 write addr", ram_addr, 32'h4005);
        end_write();
        ctl_write(16'h6000, 8'h00);
        do_read(16'hB234);
        check("R8 simple ram addr", ram_addr, 32'h1234);
        ctl_write(16'h0000, 8'h00);
        probe_write(16'hA005, 8'h77);
        check("R8 closed we", ram_we, 1'b0);
        check("R8 closed resp", resp, 2'b00);
        end_write();
    endtask

    task automatic t_pass();
        cart_type = 8'h00;
        do_read(16'h7ABC);
        check("R9 pass rom resp", resp, 2'b01);
        check("R9 pass rom addr", rom_addr, 32'h7ABC);
        do_read(16'h0005);
        check("R9 pass lower", rom_addr, 32'h0005);
        do_read(16'hB001);
        check("R9 pass ram resp", resp, 2'b10);
        check("R9 pass ram addr", ram_addr, 32'h1001);
        probe_write(16'hA002, 8'h11);
        check("R9 pass ram we", ram_we, 1'b1);
        end_write();
        ctl_write(16'h2000, 8'h07);
        ctl_write(16'h0000, 8'h0A);
        ctl_write(16'h6000, 8'h01);
        cart_type = 8'h01;
        do_read(16'h4000);
        check("R9 fields unchanged", rom_addr, 32'h10C000);
        do_read(16'h0000);
        check("R9 mode unchanged", rom_addr, 32'h0000);
        do_read(16'hA000);
        check("R9 gate unchanged", resp, 2'b00);
    endtask

    task automatic t_types();
        for (int t = 1; t <= 3; t++) begin
            cart_type = 8'(t);
            do_read(16'h4000);
            check("R10 banked unsup", unsupported, 1'b0);
            check("R10 banked addr", rom_addr, 32'h10C000);
        end
        cart_type = 8'h05;
        do_read(16'h0000);
        check("R10 type5 unsup", unsupported, 1'b1);
        check("R10 type5 resp", resp, 2'b00);
        check("R10 type5 rdata", cpu_rdata, 8'hFF);
        cart_type = 8'hFF;
        probe_write(16'hA000, 8'h01);
        check("R10 typeFF we", ram_we, 1'b0);
        check("R10 typeFF unsup", unsupported, 1'b1);
        end_write();
        cart_type = 8'h01;
    endtask

    task automatic t_unmapped();
        do_read(16'hC000);
        check("R12 C000 resp", resp, 2'b00);
        check("R12 C000 rdata", cpu_rdata, 8'hFF);
        do_read(16'h8000);
        check("R12 8000 resp", resp, 2'b00);
        do_read(16'hFF80);
        check("R12 FF80 resp", resp, 2'b00);
        probe_write(16'h8000, 8'h55);
        check("R12 8000 write we", ram_we, 1'b0);
        end_write();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_gate();
        t_low_bank();
        t_upper();
        t_lower_mode();
        t_ram_bank();
        t_pass();
        t_types();
        t_unmapped();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule